// File: doc/BRIEF.md
# Index Register Step-Compare-Branch Unit

This block holds a small file of 16-bit index registers and executes a fused loop-control operation. Each operation names one register, a signed step, a base value, a compare code and a branch target. In one acceptance the unit adds the step to the register, writes the sum back and compares the sum, as a signed number, against the base. The result reports the new value, whether the branch is taken, the target address and a signed-overflow flag. A negative step walks a table downward and a positive step walks it upward.

Operations enter on a valid/ready port and results leave on a second valid/ready port. The input is ready when the result slot is empty or is being drained in the same cycle. A result is held unchanged until it is accepted, so a stalled consumer applies back-pressure to the operation source. Address-generation logic reads the registers through separate combinational read ports. Select code 0 stands for "no index" and always reads as zero.

Top module: `idx_mtb_unit`

## Requirements
- R1: After reset every register reads as zero on all read ports and res_valid is low.
- R2: op_ready is high exactly when res_valid is low or res_ready is high. An operation is accepted on a rising edge where op_valid and op_ready are both high, and res_valid is high in the following cycle.
- R3: While res_valid is high and res_ready is low, res_valid, res_value, res_ovf, res_taken and res_target stay unchanged.
- R4: On acceptance, res_value is the selected register's old value plus op_step, taken modulo 2^16. For selects 1 to 7 that sum is written back to the register on the same edge.
- R5: res_ovf is high exactly when the old value and op_step have the same sign bit and the sum's sign bit differs from it.
- R6: res_taken compares the new value V with op_base as signed two's-complement numbers. The codes are: 0 taken if V == base, 1 if V != base, 2 if V < base, 3 if V <= base, 4 if V > base, and 5 if V >= base.
- R7: Compare codes 6 and 7 never take the branch.
- R8: Select 0 reads as zero and nothing is written back, so res_value equals op_step.
- R9: Read port i decodes rd_sel bits [3i+2:3i] and returns the register's current value on rd_data bits [16i+15:16i]. In the cycle an operation is accepted it returns the pre-update value, and the updated value from the next cycle on.
- R10: res_target equals the op_target of the accepted operation, whether or not the branch is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Operation can be accepted |
| op_sel | input | 3 | Register select, 0 = none |
| op_step | input | 16 | Signed step |
| op_base | input | 16 | Signed compare base |
| op_cond | input | 3 | Compare code |
| op_target | input | 16 | Branch target address |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_value | output | 16 | Updated register value |
| res_ovf | output | 1 | Signed overflow of the step addition |
| res_taken | output | 1 | Branch decision |
| res_target | output | 16 | Target address carried through |
| rd_sel | input | 6 | Two read-port selects, 3 bits each |
| rd_data | output | 32 | Two read-port values, 16 bits each |

## Verification
Steps of +1 and -1 walk a register across zero and past its base. This separates the six compare codes at the equal, one-below and one-above points, and it exposes any unsigned compare where the value becomes negative. Steps next to 0x7FFF and 0x8000 tell a correct signed-overflow flag from a carry flag, and they show that the sum wraps. Stalled result cycles with an operation pending show that nothing is lost or updated twice under back-pressure. Randomized streams mix select 0, the reserved codes and back-to-back use of one register, to catch write-back forwarding errors against the old-value read rule.

// File: rtl/idx_mtb_pkg.sv
package idx_mtb_pkg;
  typedef enum logic [2:0] {
    CMP_EQ  = 3'd0,
    CMP_NE  = 3'd1,
    CMP_LT  = 3'd2,
    CMP_LE  = 3'd3,
    CMP_GT  = 3'd4,
    CMP_GE  = 3'd5,
    CMP_RS6 = 3'd6,
    CMP_RS7 = 3'd7
  } cmp_code_e;
endpackage

// File: rtl/idx_regfile.sv
module idx_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 7,
  parameter int SELW = 3,
  parameter int NRD  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SELW-1:0]     wr_sel,
  input  logic [DW-1:0]       wr_data,
  input  logic [SELW-1:0]     op_rsel,
  output logic [DW-1:0]       op_rdata,
  input  logic [NRD*SELW-1:0] rd_sel,
  output logic [NRD*DW-1:0]   rd_data
);
  logic [DW-1:0] regs [NREG+1];

  assign regs[0] = '0;

  for (genvar g = 1; g <= NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (wr_en && wr_sel == SELW'(g))
        regs[g] <= wr_data;
    end
  end

  function automatic logic [DW-1:0] pick(input logic [SELW-1:0] s);
    logic [DW-1:0] v;
    v = '0;
    for (int k = 1; k <= NREG; k++)
      if (s == SELW'(k)) v = regs[k];
    return v;
  endfunction

  assign op_rdata = pick(op_rsel);

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p*DW +: DW] = pick(rd_sel[p*SELW +: SELW]);
  end
endmodule

// File: rtl/idx_step_adder.sv
module idx_step_adder #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] cur,
  input  logic [DW-1:0] step,
  output logic [DW-1:0] sum,
  output logic          ovf
);
  assign sum = cur + step;
  assign ovf = (cur[DW-1] == step[DW-1]) && (sum[DW-1] != cur[DW-1]);
endmodule

// File: rtl/idx_cmp_eval.sv
module idx_cmp_eval
  import idx_mtb_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] val,
  input  logic [DW-1:0] base,
  input  logic [2:0]    code,
  output logic          taken
);
  logic eq, lt;
  assign eq = (val == base);
  assign lt = ($signed(val) < $signed(base));

  always_comb begin
    case (cmp_code_e'(code))
      CMP_EQ:  taken = eq;
      CMP_NE:  taken = !eq;
      CMP_LT:  taken = lt;
      CMP_LE:  taken = lt || eq;
      CMP_GT:  taken = !lt && !eq;
      CMP_GE:  taken = !lt;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/idx_mtb_unit.sv
module idx_mtb_unit #(
  parameter int DW     = 16,
  parameter int NREG   = 7,
  parameter int NUM_RD = 2,
  localparam int SELW  = $clog2(NREG + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_valid,
  output logic                   op_ready,
  input  logic [SELW-1:0]        op_sel,
  input  logic [DW-1:0]          op_step,
  input  logic [DW-1:0]          op_base,
  input  logic [2:0]             op_cond,
  input  logic [DW-1:0]          op_target,
  output logic                   res_valid,
  input  logic                   res_ready,
  output logic [DW-1:0]          res_value,
  output logic                   res_ovf,
  output logic                   res_taken,
  output logic [DW-1:0]          res_target,
  input  logic [NUM_RD*SELW-1:0] rd_sel,
  output logic [NUM_RD*DW-1:0]   rd_data
);
  logic          fire;
  logic [DW-1:0] cur_val, new_val;
  logic          new_ovf, new_taken;

  assign op_ready = !res_valid || res_ready;
  assign fire     = op_valid && op_ready;

  idx_regfile #(.DW(DW), .NREG(NREG), .SELW(SELW), .NRD(NUM_RD)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (fire),
    .wr_sel   (op_sel),
    .wr_data  (new_val),
    .op_rsel  (op_sel),
    .op_rdata (cur_val),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data)
  );

  idx_step_adder #(.DW(DW)) u_add (
    .cur  (cur_val),
    .step (op_step),
    .sum  (new_val),
    .ovf  (new_ovf)
  );

  idx_cmp_eval #(.DW(DW)) u_cmp (
    .val   (new_val),
    .base  (op_base),
    .code  (op_cond),
    .taken (new_taken)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_value  <= '0;
      res_ovf    <= 1'b0;
      res_taken  <= 1'b0;
      res_target <= '0;
    end else if (fire) begin
      res_valid  <= 1'b1;
      res_value  <= new_val;
      res_ovf    <= new_ovf;
      res_taken  <= new_taken;
      res_target <= op_target;
    end else if (res_ready) begin
      res_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/idx_mtb_chk.sv
module idx_mtb_chk #(
  parameter int DW   = 16,
  parameter int SELW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic            op_ready,
  input logic [SELW-1:0] op_sel,
  input logic [DW-1:0]   op_step,
  input logic [2:0]      op_cond,
  input logic [DW-1:0]   op_target,
  input logic            res_valid,
  input logic            res_ready,
  input logic [DW-1:0]   res_value,
  input logic            res_taken,
  input logic [DW-1:0]   res_target
);
  logic fire;
  assign fire = op_valid && op_ready;

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !op_ready); // R2

  AST_FIRE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> res_valid); // R2

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_value)
      && $stable(res_taken) && $stable(res_target))); // R3

  AST_RESERVED_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_cond >= 3'd6) |=> !res_taken); // R7

  AST_SEL0_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_sel == '0) |=> (res_value == $past(op_step))); // R8

  AST_TARGET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (res_target == $past(op_target))); // R10
endmodule

bind idx_mtb_unit idx_mtb_chk #(.DW(DW), .SELW(SELW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_ready   (op_ready),
  .op_sel     (op_sel),
  .op_step    (op_step),
  .op_cond    (op_cond),
  .op_target  (op_target),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_value  (res_value),
  .res_taken  (res_taken),
  .res_target (res_target)
);

// File: tb/idx_mtb_unit_tb.sv
module idx_mtb_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [2:0]  op_sel = '0;
  logic [15:0] op_step = '0, op_base = '0, op_target = '0;
  logic [2:0]  op_cond = '0;
  logic        res_valid, res_ready = 1'b0;
  logic [15:0] res_value, res_target;
  logic        res_ovf, res_taken;
  logic [5:0]  rd_sel = '0;
  logic [31:0] rd_data;

  int n_chk = 0, n_bad = 0;

  // reference state
  int unsigned m_reg [8];
  bit          m_valid;
  int unsigned m_value, m_target;
  bit          m_ovf, m_taken;
  string       m_tag;

  always #5 clk = ~clk;

  idx_mtb_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_sel(op_sel), .op_step(op_step), .op_base(op_base), .op_cond(op_cond),
    .op_target(op_target), .res_valid(res_valid), .res_ready(res_ready),
    .res_value(res_value), .res_ovf(res_ovf), .res_taken(res_taken),
    .res_target(res_target), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit ref_taken(input int unsigned v, input int unsigned b, input int c);
    int sv, sb;
    sv = (v >= 32768) ? int'(v) - 65536 : int'(v);
    sb = (b >= 32768) ? int'(b) - 65536 : int'(b);
    case (c)
      0: return sv == sb;
      1: return sv != sb;
      2: return sv <  sb;
      3: return sv <= sb;
      4: return sv >  sb;
      5: return sv >= sb;
      default: return 1'b0;
    endcase
  endfunction

  // One cycle: drive at negedge, check combinational outputs, step the model,
  // then check the registered outputs at the next negedge.
  task automatic cyc(input bit v, input int s, input int unsigned st,
                     input int unsigned b, input int c, input int unsigned t,
                     input bit rr, input int s2);
    bit exp_rdy, fire, was_stall;
    int unsigned old, sum;
    op_valid = v; op_sel = 3'(s); op_step = 16'(st); op_base = 16'(b);
    op_cond = 3'(c); op_target = 16'(t); res_ready = rr;
    rd_sel = {3'(s2), 3'(s)};
    #1;
    exp_rdy = !m_valid || rr;
    chk("R2 op_ready", op_ready, exp_rdy);
    chk("R9 rd port0 old value", rd_data[15:0], m_reg[s]);
    chk("R9 rd port1", rd_data[31:16], m_reg[s2]);
    fire = v && exp_rdy;
    was_stall = m_valid && !rr;
    if (fire) begin
      old = m_reg[s];
      sum = (old + (st & 16'hFFFF)) & 16'hFFFF;
      m_value = sum;
      m_ovf = (old[15] == st[15]) && (sum[15] != old[15]);
      m_taken = ref_taken(sum, b & 16'hFFFF, c);
      m_target = t & 16'hFFFF;
      if (s != 0) m_reg[s] = sum;
      m_valid = 1'b1;
      m_tag = (c >= 6) ? "R7" : "R6";
    end else if (rr) begin
      m_valid = 1'b0;
    end
    @(negedge clk);
    if (was_stall && !fire) begin
      chk("R3 held valid", res_valid, 1);
      chk("R3 held value", res_value, m_value);
      chk("R3 held taken", res_taken, m_taken);
    end
    chk("R2 res_valid", res_valid, m_valid);
    if (m_valid) begin
      chk((s == 0 && fire) ? "R8 value" : "R4 value", res_value, m_value);
      chk("R5 ovf", res_ovf, m_ovf);
      chk({m_tag, " taken"}, res_taken, m_taken);
      chk("R10 target", res_target, m_target);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = 0;
    m_valid = 0; m_value = 0; m_target = 0; m_ovf = 0; m_taken = 0; m_tag = "R6";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd_sel = {3'(i), 3'(i)};
      #1;
      chk("R1 reg zero", rd_data[15:0], 0);
      chk("R1 reg zero p1", rd_data[31:16], 0);
      chk("R1 res_valid", res_valid, 0);
      @(negedge clk);
    end
    // R4/R6: walk register 1 upward by 1 around base 3, every compare code
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 5; k++) cyc(1, 1, 1, 3, c, 16'h100 + k, 1, 1);
      for (int k = 0; k < 5; k++) cyc(1, 1, 16'hFFFF, 3, c, 16'h200 + k, 1, 1);
    end
    // R6 signed: walk register 2 across zero downward
    for (int k = 0; k < 6; k++) cyc(1, 2, 16'hFFFF, 16'hFFFE, 2, 16'h300, 1, 2);
    for (int k = 0; k < 6; k++) cyc(1, 2, 16'hFFFF, 16'hFFFE, 4, 16'h300, 1, 2);
    // R5: overflow corners and large steps
    cyc(1, 3, 16'h7FFF, 0, 0, 1, 1, 3);
    cyc(1, 3, 16'h0001, 16'h8000, 0, 2, 1, 3);
    cyc(1, 3, 16'hFFFF, 0, 5, 3, 1, 3);
    cyc(1, 4, 16'h8000, 0, 2, 4, 1, 4);
    cyc(1, 4, 16'h8000, 0, 0, 5, 1, 4);
    cyc(1, 5, 16'h1234, 16'h1234, 0, 6, 1, 5);
    // R8: select 0
    cyc(1, 0, 16'h0042, 16'h0042, 0, 7, 1, 0);
    cyc(1, 0, 16'h7FFF, 0, 4, 8, 1, 0);
    // R3: stall with a pending op, then drain
    cyc(1, 6, 5, 5, 0, 9, 0, 6);
    cyc(1, 6, 5, 5, 0, 10, 0, 6);
    cyc(1, 6, 5, 5, 0, 11, 0, 6);
    cyc(1, 6, 5, 5, 0, 12, 1, 6);
    cyc(0, 6, 0, 0, 0, 0, 1, 6);
    // randomized mix
    for (int n = 0; n < 3000; n++) begin
      int unsigned st;
      case ($urandom_range(0, 3))
        0: st = 1;
        1: st = 16'hFFFF;
        2: st = $urandom_range(0, 65535);
        default: st = 16'h8000 - $urandom_range(0, 2);
      endcase
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 7), st,
          $urandom_range(0, 65535) & 16'h800F, $urandom_range(0, 7),
          $urandom_range(0, 65535), $urandom_range(0, 2) != 0, $urandom_range(0, 7));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule